// File: doc/BRIEF.md
# Accumulator Store Address Sequencer

This block works out where a store of the accumulator lands for four pointer-based addressing modes of a 16-bit processor with a 24-bit address space. It also works out how many bytes the store writes and how many processor cycles the store costs. The decoder hands it a two-bit mode code, the instruction's operand byte and a snapshot of the registers it needs: stack pointer, direct-page base, data bank, Y index and accumulator, plus the memory-width and index-width flags.

After a start pulse the block takes those inputs in and reads the two or three pointer bytes it needs through a byte-wide read port, one byte per cycle. It then issues one or two byte writes. A done pulse comes with the final write, together with the cycle cost. Fetching the opcode, executing other instructions and arbitrating the bus are left to the surrounding core.

Top module: `acc_store_agu`

## Requirements
- R1: Mode code 0 (stack-relative) reads no pointer and writes to the 24-bit sum of SP and the zero-extended operand.
- R2: Mode code 1 (direct-page long indirect) reads pointer bytes from D+operand, D+operand+1 and D+operand+2, in that order. The byte read from D+operand is bits 7:0 of the 24-bit target, the next byte is bits 15:8, and the last byte is bits 23:16.
- R3: Mode code 2 (stack-relative indirect, Y-indexed) reads a 16-bit pointer from SP+operand (low byte first). The target is the data bank in bits 23:16 and (pointer + index) modulo 2^16 in bits 15:0.
- R4: Mode code 3 (direct-page long indirect, Y-indexed) reads a 24-bit pointer as in R2. The target is (pointer + index) modulo 2^24.
- R5: When xFlag is 1 the index is the low byte of Y, zero-extended. When xFlag is 0 it is all 16 bits of Y.
- R6: When mFlag is 1 a single write of A[7:0] goes to the target. When mFlag is 0, A[7:0] goes to the target and then A[15:8] goes to target+1 (modulo 2^24) in the next cycle.
- R7: The reported cycle cost is 4 for mode 0, 6 for modes 1 and 3 and 7 for mode 2, plus 1 when mFlag is 0.
- R8: Modes 1 and 3 add one more cycle to the cost whenever D[7:0] is nonzero. Modes 0 and 2 never take this extra cycle.
- R9: Pointer reads run one per cycle, starting in the cycle after start is sampled. The writes follow at once, and done is high in the cycle of the final write. busy stays high from the first cycle after start until that write.
- R10: A start that arrives while busy is high is ignored. It causes no extra reads or writes, and busy falls as it would have without it.
- R11: During and straight after reset, busy, done, rdEn and wrEn are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a store; inputs below are sampled with it |
| mode | input | 2 | Addressing mode code (0..3, see R1 to R4) |
| operand | input | 8 | Instruction operand byte |
| sp | input | 16 | Stack pointer |
| dp | input | 16 | Direct-page base |
| dbank | input | 8 | Data bank |
| yIdx | input | 16 | Y index register |
| acc | input | 16 | Accumulator |
| mFlag | input | 1 | 1 = byte-wide store |
| xFlag | input | 1 | 1 = byte-wide index |
| rdEn | output | 1 | Pointer byte read request |
| rdAddr | output | 24 | Pointer byte address |
| rdData | input | 8 | Read data, valid in the same cycle as rdEn |
| wrEn | output | 1 | Byte write strobe |
| wrAddr | output | 24 | Write address |
| wrData | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | High with the final write |
| cycleCount | output | 4 | Cycle cost, valid when done is high |

## Verification
The bench builds the block with its default parameters: an 8-bit bank and a 16-bit word, which give a 24-bit address, and a 4-bit cost field. At these widths the bench can drive an SP or D sum that crosses into bank 1, an indexed sum that wraps inside the bank in mode 2, and a high-byte write that carries from 0x00FFFF into the bank bits. These widths also let the largest cost, 8, appear with both added cycles. A memory model computed from the address supplies the pointer bytes, so every read address and every target can be predicted.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

  typedef enum logic [1:0] {
    MODE_SR   = 2'd0,
    MODE_DPL  = 2'd1,
    MODE_SRIY = 2'd2,
    MODE_DPLY = 2'd3
  } amode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       load;
    logic       ptrRd;
    logic [1:0] ptrIdx;
    logic       wrLo;
    logic       wrHi;
  } strobe_t;

  // bit 0 of the mode code marks a direct-page (three-byte pointer) mode
  function automatic logic isLong(amode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/acc_store_ctrl.sv
module acc_store_ctrl
  import acc_store_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  amode_e  mode,
  input  logic    mFlag,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_WLO, S_WHI} state_e;

  state_e     state;
  amode_e     modeQ;
  logic       wideQ;
  logic [1:0] idxQ;
  logic [1:0] lastIdx;

  assign lastIdx = isLong(modeQ) ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      modeQ <= MODE_SR;
      wideQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          modeQ <= mode;
          wideQ <= !mFlag;
          idxQ  <= '0;
          state <= (mode == MODE_SR) ? S_WLO : S_PTR;
        end
        S_PTR: begin
          idxQ <= idxQ + 2'd1;
          if (idxQ == lastIdx) state <= S_WLO;
        end
        S_WLO: state <= wideQ ? S_WHI : S_IDLE;
        S_WHI: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load   = (state == S_IDLE) && start;
    stb.ptrRd  = (state == S_PTR);
    stb.ptrIdx = idxQ;
    stb.wrLo   = (state == S_WLO);
    stb.wrHi   = (state == S_WHI);
  end

  assign busy = (state != S_IDLE);
  assign done = ((state == S_WLO) && !wideQ) || (state == S_WHI);

  // R9: the operation closes right after done
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6: a high-byte write always follows a low-byte write
  p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrHi |-> $past(stb.wrLo));

endmodule

// File: rtl/acc_store_dp.sv
module acc_store_dp
  import acc_store_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 4,
  parameter int CYC_SR    = 4,
  parameter int CYC_DPL   = 6,
  parameter int CYC_SRIY  = 7,
  localparam int ADDR_W   = BANK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  amode_e            mode,
  input  logic [7:0]        operand,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] dp,
  input  logic [BANK_W-1:0] dbank,
  input  logic [WORD_W-1:0] yIdx,
  input  logic [WORD_W-1:0] acc,
  input  logic              mFlag,
  input  logic              xFlag,
  input  logic [7:0]        rdData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic [CNT_W-1:0]  cycleCount
);

  amode_e            modeQ;
  logic [7:0]        opQ;
  logic [WORD_W-1:0] spQ, dpQ, yQ, accQ;
  logic [BANK_W-1:0] dbQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] ptrBase, target;
  logic [CNT_W-1:0]  costNext;

  // cycle cost from the live inputs at load time
  always_comb begin
    unique case (mode)
      MODE_SR:   costNext = CNT_W'(CYC_SR);
      MODE_SRIY: costNext = CNT_W'(CYC_SRIY);
      default:   costNext = CNT_W'(CYC_DPL);
    endcase
    if (!mFlag) costNext = costNext + 1'b1;
    if (isLong(mode) && (dp[7:0] != 8'h00)) costNext = costNext + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_SR; opQ <= '0; spQ <= '0; dpQ <= '0; yQ <= '0;
      accQ <= '0; dbQ <= '0; ptrQ <= '0; cycleCount <= '0;
    end else if (stb.load) begin
      modeQ      <= mode;
      opQ        <= operand;
      spQ        <= sp;
      dpQ        <= dp;
      dbQ        <= dbank;
      accQ       <= acc;
      yQ         <= xFlag ? {{(WORD_W-8){1'b0}}, yIdx[7:0]} : yIdx;
      ptrQ       <= '0;
      cycleCount <= costNext;
    end else if (stb.ptrRd) begin
      ptrQ[stb.ptrIdx*8 +: 8] <= rdData;
    end
  end

  always_comb begin
    ptrBase = isLong(modeQ) ? (ADDR_W'(dpQ) + ADDR_W'(opQ))
                            : (ADDR_W'(spQ) + ADDR_W'(opQ));
    unique case (modeQ)
      MODE_SR:   target = ptrBase;
      MODE_DPL:  target = ptrQ;
      MODE_SRIY: target = {dbQ, ptrQ[WORD_W-1:0] + yQ};
      default:   target = ptrQ + ADDR_W'(yQ);
    endcase
  end

  assign rdEn   = stb.ptrRd;
  assign rdAddr = ptrBase + ADDR_W'(stb.ptrIdx);
  assign wrEn   = stb.wrLo | stb.wrHi;
  assign wrAddr = stb.wrHi ? target + 1'b1 : target;
  assign wrData = stb.wrHi ? accQ[15:8] : accQ[7:0];

  // R6: the high byte lands one address above the low byte
  p_hi_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrHi |-> wrAddr == $past(wrAddr) + 1'b1);

  // R9: reads and writes never share a cycle
  p_rd_wr_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !wrEn);

endmodule

// File: rtl/acc_store_agu.sv
module acc_store_agu
  import acc_store_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 4,
  parameter int CYC_SR   = 4,
  parameter int CYC_DPL  = 6,
  parameter int CYC_SRIY = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [1:0]                mode,
  input  logic [7:0]                operand,
  input  logic [WORD_W-1:0]         sp,
  input  logic [WORD_W-1:0]         dp,
  input  logic [BANK_W-1:0]         dbank,
  input  logic [WORD_W-1:0]         yIdx,
  input  logic [WORD_W-1:0]         acc,
  input  logic                      mFlag,
  input  logic                      xFlag,
  output logic                      rdEn,
  output logic [BANK_W+WORD_W-1:0]  rdAddr,
  input  logic [7:0]                rdData,
  output logic                      wrEn,
  output logic [BANK_W+WORD_W-1:0]  wrAddr,
  output logic [7:0]                wrData,
  output logic                      busy,
  output logic                      done,
  output logic [CNT_W-1:0]          cycleCount
);

  strobe_t stb;
  amode_e  modeE;

  assign modeE = amode_e'(mode);

  acc_store_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(modeE), .mFlag(mFlag),
    .stb(stb), .busy(busy), .done(done)
  );

  acc_store_dp #(
    .BANK_W(BANK_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .CYC_SR(CYC_SR), .CYC_DPL(CYC_DPL), .CYC_SRIY(CYC_SRIY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(modeE), .operand(operand),
    .sp(sp), .dp(dp), .dbank(dbank), .yIdx(yIdx), .acc(acc),
    .mFlag(mFlag), .xFlag(xFlag), .rdData(rdData),
    .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cycleCount(cycleCount)
  );

  // R9: done only ever comes with a write
  p_done_with_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> wrEn);

  // R11: no bus activity while idle
  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !wrEn));

endmodule

// File: tb/acc_store_agu_tb.sv
module acc_store_agu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [7:0]  operand = '0;
  logic [15:0] sp = '0, dp = '0, yIdx = '0, acc = '0;
  logic [7:0]  dbank = '0;
  logic        mFlag = 1'b1, xFlag = 1'b1;
  logic        rdEn, wrEn, busy, done;
  logic [23:0] rdAddr, wrAddr;
  logic [7:0]  rdData, wrData;
  logic [3:0]  cycleCount;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memByte(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  assign rdData = memByte(rdAddr);

  acc_store_agu u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .operand(operand),
    .sp(sp), .dp(dp), .dbank(dbank), .yIdx(yIdx), .acc(acc),
    .mFlag(mFlag), .xFlag(xFlag), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .done(done), .cycleCount(cycleCount)
  );

  typedef struct {
    bit          isWr;
    int          when;
    logic [23:0] addr;
    logic [7:0]  data;
    bit          fin;
    int          cost;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every bus event
  always @(negedge clk) begin
    if (rstN && (rdEn || wrEn)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected bus event addr", int'(wrEn ? wrAddr : rdAddr), 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.isWr == wrEn, it.tag, "event kind", int'(wrEn), int'(it.isWr));
        check(cyc == it.when, {it.tag, " R9"}, "event cycle", cyc, it.when);
        check((it.isWr ? wrAddr : rdAddr) == it.addr, it.tag, "address",
              int'(it.isWr ? wrAddr : rdAddr), int'(it.addr));
        if (it.isWr) begin
          check(wrData == it.data, {it.tag, " R6"}, "write data", int'(wrData), int'(it.data));
          check(done == it.fin, {it.tag, " R9"}, "done", int'(done), int'(it.fin));
          if (it.fin)
            check(int'(cycleCount) == it.cost, {it.tag, " R7 R8"}, "cycle cost",
                  int'(cycleCount), it.cost);
        end
      end
    end
  end

  // driver: computes expectations from the requirements, then starts the op
  task automatic runOp(logic [1:0] md, logic [7:0] op, logic [15:0] s, logic [15:0] d,
                       logic [7:0] db, logic [15:0] y, logic [15:0] a,
                       logic m, logic x, string tag, bit poke = 1'b0);
    logic [23:0] base, ptr, tgt;
    logic [15:0] idx;
    int nPtr, c, cost;
    item_t it;
    @(negedge clk);
    c = cyc;
    base = md[0] ? (24'(d) + 24'(op)) : (24'(s) + 24'(op));
    nPtr = (md == 2'd0) ? 0 : (md[0] ? 3 : 2);
    ptr = '0;
    for (int i = 0; i < nPtr; i++) begin
      it = '{1'b0, c + 1 + i, base + 24'(i), 8'h00, 1'b0, 0, tag};
      sb.push_back(it);
      ptr[i*8 +: 8] = memByte(base + 24'(i));
    end
    idx = x ? {8'h00, y[7:0]} : y;
    case (md)
      2'd0:    tgt = base;
      2'd1:    tgt = ptr;
      2'd2:    tgt = {db, ptr[15:0] + idx};
      default: tgt = ptr + 24'(idx);
    endcase
    cost = (md == 2'd0) ? 4 : (md == 2'd2) ? 7 : 6;
    if (!m) cost++;
    if (md[0] && d[7:0] != 8'h00) cost++;
    it = '{1'b1, c + 1 + nPtr, tgt, a[7:0], m, cost, tag};
    sb.push_back(it);
    if (!m) begin
      it = '{1'b1, c + 2 + nPtr, tgt + 24'd1, a[15:8], 1'b1, cost, tag};
      sb.push_back(it);
    end
    mode = md; operand = op; sp = s; dp = d; dbank = db; yIdx = y; acc = a;
    mFlag = m; xFlag = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a second start while busy, with a different mode
      mode = ~md; operand = op + 8'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (nPtr + (m ? 1 : 2) - 1) @(negedge clk);
    end else begin
      repeat (nPtr + (m ? 1 : 2)) @(negedge clk);
    end
    check(!busy, {tag, " R9 R10"}, "busy after last write", int'(busy), 0);
    check(sb.size() == 0, {tag, " R9"}, "pending events", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rdEn && !wrEn, "R11", "outputs in reset",
          int'({busy, done, rdEn, wrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rdEn && !wrEn, "R11", "outputs after reset",
          int'({busy, done, rdEn, wrEn}), 0);
    // R1 R7: stack-relative, byte store
    runOp(2'd0, 8'h20, 16'h01F0, 16'h0000, 8'h00, 16'h0000, 16'hBEEF, 1'b1, 1'b1, "R1");
    // R6: word store whose high byte carries into the bank
    runOp(2'd0, 8'h00, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 16'hA55A, 1'b0, 1'b1, "R6");
    // R2 R8: long indirect, aligned D, byte store
    runOp(2'd1, 8'h10, 16'h0000, 16'h0000, 8'h00, 16'h0000, 16'h0077, 1'b1, 1'b1, "R2");
    // R8: long indirect, unaligned D, word store
    runOp(2'd1, 8'h05, 16'h0000, 16'h1234, 8'h00, 16'h0000, 16'h1357, 1'b0, 1'b0, "R8");
    // R3 R5: byte index masks Y
    runOp(2'd2, 8'h03, 16'h01F8, 16'h00AA, 8'h7E, 16'h12FF, 16'h00C3, 1'b1, 1'b1, "R3");
    // R3: full Y index wraps inside the bank, word store
    runOp(2'd2, 8'h40, 16'h2000, 16'h0000, 8'h12, 16'hFFFF, 16'h6789, 1'b0, 1'b0, "R3");
    // R4: long indexed with full Y
    runOp(2'd3, 8'h22, 16'h0000, 16'h0100, 8'h00, 16'h8000, 16'hCAFE, 1'b0, 1'b0, "R4");
    // R5 R8: long indexed, byte index, unaligned D
    runOp(2'd3, 8'hFF, 16'h0000, 16'h00FF, 8'h00, 16'hAB80, 16'h0042, 1'b1, 1'b1, "R5");
    // R10: start while busy is ignored
    runOp(2'd1, 8'h30, 16'h0000, 16'h0200, 8'h00, 16'h0000, 16'h9911, 1'b0, 1'b1, "R10", 1'b1);
    runOp(2'd0, 8'h08, 16'h0100, 16'h0000, 8'h00, 16'h0000, 16'h3344, 1'b1, 1'b1, "R10", 1'b1);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule